// File: doc/BRIEF.md
# USB Power Delivery Port Status Signal Generator

This block turns the protocol events of one USB Power Delivery port into a set of level status signals that can drive general-purpose pins. Its inputs are one-cycle event pulses from the protocol engine (attach, detach, hard reset, power-role swap, Request received or sent, Accept sent, PS_RDY sent or received) and a few levels: the current power and data roles, the plug orientation at attach, and the PDO index that goes with an Accept. It also takes two asynchronous system pins: a barrel-jack sense and an active-low fault input.

Its outputs are:
- a negotiation-in-progress flag, which follows a different sequence in source role than in sink role;
- plug-present, orientation, attached-as-sink and UFP indicators;
- the negotiated source PDO, as a 3-bit binary code and as one-hot flags for the low PDO numbers;
- an unconstrained-power flag driven by the barrel-jack edges;
- a request for Type-C error recovery.

The source contract outputs update only after a programmable transition delay. This delay is counted in clock cycles and starts when the Accept is sent.

Top module: `pd_status_gpio`

## Requirements
- R1: After reset, every output is 0.
- R2: In source role (`role_src`=1), `ev_req_rx` sets `nego_busy` at the next edge, and `ev_psrdy_tx` clears it. In this role `ev_req_tx` and `ev_psrdy_rx` have no effect on it.
- R3: In sink role (`role_src`=0), `ev_req_tx` sets `nego_busy` at the next edge, and `ev_psrdy_rx` clears it. In this role `ev_req_rx` and `ev_psrdy_tx` have no effect on it.
- R4: `ev_detach` clears `nego_busy`, `plug_att`, `orient`, `attached_sink`, `pdo_code` and `pdo_onehot` at the next edge. `ev_hard_reset` clears `nego_busy`, `attached_sink` and the contract outputs.
- R5: When `ev_accept_tx` arrives in source role, the value of `pdo_idx` is captured. `pdo_code` takes that value exactly `T_SRC_TRANS` edges after the capture edge, and not before. A second Accept during the wait restarts the wait with the new index.
- R6: `pdo_onehot[i]` is 1 exactly when `pdo_code` equals i+1, for i = 0..3. Codes 0 and 5 to 7 give all zeros, so a new contract clears any earlier flag.
- R7: A detach, hard reset or power-role swap during the wait cancels the pending contract. `pdo_code` stays 0 afterwards.
- R8: `barrel_in` passes through a two-flop synchroniser. A rising edge sets `unconstrained` and a falling edge clears it, 3 edges after the pin changes.
- R9: `fault_n_in` passes through a two-flop synchroniser. `err_recovery` is 1 from the 2nd edge after the pin goes low, and 0 from the 2nd edge after it goes high.
- R10: At `ev_attach`, `plug_att` goes to 1 and `orient` takes `attach_cc2` (1 = upside-down on CC2, 0 = upside-up on CC1). With nothing attached, `orient` is 0.
- R11: `ev_attach` with `role_src`=0 sets `attached_sink`. It is cleared by `ev_detach`, `ev_hard_reset` or `ev_pr_swap`.
- R12: `ufp_ind` is the registered value of `plug_att` AND `dr_ufp`, one edge late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| role_src | input | 1 | power role level, 1 = source |
| dr_ufp | input | 1 | data role level, 1 = UFP |
| attach_cc2 | input | 1 | orientation at attach, 1 = CC2 |
| ev_attach | input | 1 | attach pulse |
| ev_detach | input | 1 | detach pulse |
| ev_hard_reset | input | 1 | hard reset pulse |
| ev_pr_swap | input | 1 | power-role swap start pulse |
| ev_req_rx | input | 1 | Request received pulse |
| ev_req_tx | input | 1 | Request about to be sent pulse |
| ev_accept_tx | input | 1 | Accept sent pulse |
| ev_psrdy_tx | input | 1 | PS_RDY sent pulse |
| ev_psrdy_rx | input | 1 | PS_RDY received pulse |
| pdo_idx | input | 3 | negotiated PDO number, valid with ev_accept_tx |
| barrel_in | input | 1 | asynchronous barrel-jack sense |
| fault_n_in | input | 1 | asynchronous active-low fault |
| nego_busy | output | 1 | negotiation in progress |
| plug_att | output | 1 | plug attached |
| orient | output | 1 | cable orientation |
| attached_sink | output | 1 | attached as sink |
| ufp_ind | output | 1 | data role is UFP |
| pdo_code | output | 3 | binary source PDO contract number |
| pdo_onehot | output | 4 | one-hot contract flags for PDO1 to PDO4 |
| unconstrained | output | 1 | unconstrained power |
| err_recovery | output | 1 | error recovery request |

## Verification
Event-driven outputs are due one edge after the pulse is captured. The synchronised pins act after 2 edges (fault) or 3 edges (barrel jack). The contract code changes exactly `T_SRC_TRANS` edges after the Accept is captured.

The bench drives inputs on the falling clock edge and samples on the falling edge after the edge where a result is due. For the delayed paths it also samples one edge earlier, which pins the latency down from both sides. It sweeps all eight PDO indices, and both roles against all four negotiation events.

// File: rtl/pd_status_gpio.sv
module pd_status_gpio #(
  parameter int T_SRC_TRANS = 20,
  parameter int ONEHOT_N    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       role_src,
  input  logic       dr_ufp,
  input  logic       attach_cc2,
  input  logic       ev_attach,
  input  logic       ev_detach,
  input  logic       ev_hard_reset,
  input  logic       ev_pr_swap,
  input  logic       ev_req_rx,
  input  logic       ev_req_tx,
  input  logic       ev_accept_tx,
  input  logic       ev_psrdy_tx,
  input  logic       ev_psrdy_rx,
  input  logic [2:0] pdo_idx,
  input  logic       barrel_in,
  input  logic       fault_n_in,
  output logic       nego_busy,
  output logic       plug_att,
  output logic       orient,
  output logic       attached_sink,
  output logic       ufp_ind,
  output logic [2:0] pdo_code,
  output logic [ONEHOT_N-1:0] pdo_onehot,
  output logic       unconstrained,
  output logic       err_recovery
);
  localparam int CW = $clog2(T_SRC_TRANS + 1);
  localparam logic [CW-1:0] T_LOAD = CW'(T_SRC_TRANS);

  logic nego_set, nego_clr, kill;
  logic [CW-1:0] cnt;
  logic pend;
  logic [2:0] pend_idx;
  logic [1:0] bj_sync, ft_sync;
  logic bj_prev;

  assign nego_set = role_src ? ev_req_rx   : ev_req_tx;
  assign nego_clr = role_src ? ev_psrdy_tx : ev_psrdy_rx;
  assign kill     = ev_detach | ev_hard_reset | ev_pr_swap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            nego_busy <= 1'b0;
    else if (ev_detach || ev_hard_reset)   nego_busy <= 1'b0;
    else if (nego_clr)                     nego_busy <= 1'b0;
    else if (nego_set)                     nego_busy <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      plug_att <= 1'b0;
      orient   <= 1'b0;
    end else if (ev_detach) begin
      plug_att <= 1'b0;
      orient   <= 1'b0;
    end else if (ev_attach) begin
      plug_att <= 1'b1;
      orient   <= attach_cc2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                       attached_sink <= 1'b0;
    else if (ev_detach || ev_hard_reset || ev_pr_swap) attached_sink <= 1'b0;
    else if (ev_attach && !role_src)                  attached_sink <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ufp_ind <= 1'b0;
    else        ufp_ind <= plug_att & dr_ufp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_idx <= '0;
      cnt      <= '0;
      pdo_code <= '0;
    end else if (kill) begin
      pend     <= 1'b0;
      cnt      <= '0;
      pdo_code <= '0;
    end else if (ev_accept_tx && role_src) begin
      pend     <= 1'b1;
      pend_idx <= pdo_idx;
      cnt      <= T_LOAD;
    end else if (pend) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        pend     <= 1'b0;
        pdo_code <= pend_idx;
      end
    end

  for (genvar i = 0; i < ONEHOT_N; i++) begin : g_onehot
    assign pdo_onehot[i] = (pdo_code == 3'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bj_sync       <= '0;
      bj_prev       <= 1'b0;
      ft_sync       <= '1;
      unconstrained <= 1'b0;
    end else begin
      bj_sync <= {bj_sync[0], barrel_in};
      bj_prev <= bj_sync[1];
      ft_sync <= {ft_sync[0], fault_n_in};
      if (bj_sync[1] && !bj_prev)      unconstrained <= 1'b1;
      else if (!bj_sync[1] && bj_prev) unconstrained <= 1'b0;
    end

  assign err_recovery = ~ft_sync[1];
endmodule

module pd_status_gpio_chk #(
  parameter int ONEHOT_N = 4
) (
  input logic clk,
  input logic rst_n,
  input logic role_src,
  input logic ev_detach,
  input logic ev_hard_reset,
  input logic ev_pr_swap,
  input logic ev_req_rx,
  input logic ev_psrdy_tx,
  input logic ev_accept_tx,
  input logic nego_busy,
  input logic plug_att,
  input logic orient,
  input logic attached_sink,
  input logic [2:0] pdo_code,
  input logic [ONEHOT_N-1:0] pdo_onehot
);
  a_r2_src_set: assert property (@(posedge clk) disable iff (!rst_n)
    role_src && ev_req_rx && !ev_psrdy_tx && !ev_detach && !ev_hard_reset |=> nego_busy);
  a_r4_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_detach |=> !nego_busy && !plug_att && !orient && !attached_sink && pdo_code == 3'd0);
  a_r5_accept_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_tx && role_src && !ev_detach && !ev_hard_reset && !ev_pr_swap |=> $stable(pdo_code));
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pdo_onehot));
  a_r10_orient_needs_plug: assert property (@(posedge clk) disable iff (!rst_n) orient |-> plug_att);
endmodule

bind pd_status_gpio pd_status_gpio_chk #(.ONEHOT_N(ONEHOT_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .role_src(role_src), .ev_detach(ev_detach),
  .ev_hard_reset(ev_hard_reset), .ev_pr_swap(ev_pr_swap), .ev_req_rx(ev_req_rx),
  .ev_psrdy_tx(ev_psrdy_tx), .ev_accept_tx(ev_accept_tx), .nego_busy(nego_busy),
  .plug_att(plug_att), .orient(orient), .attached_sink(attached_sink),
  .pdo_code(pdo_code), .pdo_onehot(pdo_onehot)
);

// File: tb/pd_status_gpio_bench.sv
`timescale 1ns/1ps
module pd_status_gpio_bench;
  localparam int T = 6;
  logic clk = 0, rst_n = 0;
  logic role_src = 0, dr_ufp = 0, attach_cc2 = 0;
  logic ev_attach = 0, ev_detach = 0, ev_hard_reset = 0, ev_pr_swap = 0;
  logic ev_req_rx = 0, ev_req_tx = 0, ev_accept_tx = 0, ev_psrdy_tx = 0, ev_psrdy_rx = 0;
  logic [2:0] pdo_idx = 0;
  logic barrel_in = 0, fault_n_in = 1;
  logic nego_busy, plug_att, orient, attached_sink, ufp_ind, unconstrained, err_recovery;
  logic [2:0] pdo_code;
  logic [3:0] pdo_onehot;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pd_status_gpio #(.T_SRC_TRANS(T), .ONEHOT_N(4)) u_pd_status_gpio (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    ev_attach = 0; ev_detach = 0; ev_hard_reset = 0; ev_pr_swap = 0;
    ev_req_rx = 0; ev_req_tx = 0; ev_accept_tx = 0; ev_psrdy_tx = 0; ev_psrdy_rx = 0;
  endtask

  function automatic logic [3:0] exp_oh(int c);
    return (c >= 1 && c <= 4) ? 4'(1 << (c - 1)) : 4'd0;
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 nego", nego_busy, 0); chk("R1 plug", plug_att, 0);
    chk("R1 code", pdo_code, 0); chk("R1 err", err_recovery, 0);
    chk("R1 unc", unconstrained, 0); chk("R1 sink", attached_sink, 0);
    rst_n = 1; step();

    // R10 / R11 / R12 attach as sink, upside-down
    role_src = 0; attach_cc2 = 1; dr_ufp = 1; ev_attach = 1; step(); clear_ev();
    chk("R10 plug", plug_att, 1); chk("R10 orient", orient, 1);
    chk("R11 sink set", attached_sink, 1); chk("R12 ufp early", ufp_ind, 0);
    step(); chk("R12 ufp", ufp_ind, 1);
    ev_pr_swap = 1; step(); clear_ev(); chk("R11 swap clears", attached_sink, 0);

    // R2 / R3 both roles, all four events
    for (int r = 0; r < 2; r++) begin
      role_src = r[0];
      ev_req_rx = 1; step(); clear_ev(); chk(r ? "R2 req_rx sets" : "R3 req_rx ignored", nego_busy, r);
      ev_req_tx = 1; step(); clear_ev(); chk(r ? "R2 req_tx ignored" : "R3 req_tx sets", nego_busy, 1);
      ev_psrdy_rx = 1; step(); clear_ev(); chk(r ? "R2 psrdy_rx ignored" : "R3 psrdy_rx clears", nego_busy, r);
      ev_psrdy_tx = 1; step(); clear_ev(); chk(r ? "R2 psrdy_tx clears" : "R3 psrdy_tx ignored", nego_busy, 0);
    end
    role_src = 1; ev_req_rx = 1; step(); clear_ev();
    ev_detach = 1; step(); clear_ev();
    chk("R4 detach nego", nego_busy, 0); chk("R4 detach plug", plug_att, 0);
    chk("R10 orient detached", orient, 0);
    step(); chk("R12 ufp detached", ufp_ind, 0);

    // R5 / R6 sweep all indices in source role
    ev_attach = 1; attach_cc2 = 0; step(); clear_ev();
    chk("R10 orient cc1", orient, 0); chk("R11 source no sink", attached_sink, 0);
    for (int k = 0; k < 8; k++) begin
      automatic logic [2:0] prev = pdo_code;
      pdo_idx = 3'(k); ev_accept_tx = 1; step(); clear_ev();
      step(T - 1); chk("R5 not early", pdo_code, prev);
      step(); chk("R5 commit", pdo_code, k); chk("R6 onehot", pdo_onehot, exp_oh(k));
    end
    // R5 restart
    pdo_idx = 2; ev_accept_tx = 1; step(); clear_ev();
    step(2); pdo_idx = 3; ev_accept_tx = 1; step(); clear_ev();
    step(T - 1); chk("R5 restart wait", pdo_code, 7);
    step(); chk("R5 restart value", pdo_code, 3);
    // R4 hard reset clears contract
    ev_hard_reset = 1; step(); clear_ev(); chk("R4 hreset code", pdo_code, 0);
    // R7 cancel pending by each kill event
    for (int m = 0; m < 3; m++) begin
      pdo_idx = 4; ev_accept_tx = 1; step(); clear_ev(); step(2);
      ev_detach = (m == 0); ev_hard_reset = (m == 1); ev_pr_swap = (m == 2);
      step(); clear_ev(); step(T + 2);
      chk("R7 cancelled", pdo_code, 0);
    end
    // Accept in sink role ignored
    role_src = 0; pdo_idx = 1; ev_accept_tx = 1; step(); clear_ev(); step(T + 2);
    chk("R5 sink accept ignored", pdo_code, 0);

    // R8 barrel edges
    barrel_in = 1; step(2); chk("R8 rise early", unconstrained, 0);
    step(); chk("R8 rise", unconstrained, 1);
    barrel_in = 0; step(2); chk("R8 fall early", unconstrained, 1);
    step(); chk("R8 fall", unconstrained, 0);
    // R9 fault
    fault_n_in = 0; step(); chk("R9 early", err_recovery, 0);
    step(); chk("R9 low", err_recovery, 1);
    fault_n_in = 1; step(); chk("R9 hold", err_recovery, 1);
    step(); chk("R9 high no action", err_recovery, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule